// File: doc/BRIEF.md
# Load-Scheduled Variable-Frequency Complementary PWM

This block drives the gates of a main switch and an auxiliary switch as a complementary pair. The switching period is chosen from a 12-bit load-current sample. At heavy load the pair runs at a fixed short period. At light load it runs at a fixed long period, which lets the magnetising current swing negative so that soft turn-on is recovered. Between two programmable current thresholds the period moves linearly from one limit to the other, so the frequency never jumps.

A duty command from an external voltage loop sets the main-switch on-time as a 12-bit fraction of the active period. The new period and the new on-time are latched together at a cycle boundary. A one-clock sample strobe marks that boundary, so the load-current converter takes a sample once per switching cycle at whatever rate is in force. A programmable dead time delays every rising gate edge. Both gates stay low during reset and while the block is disabled.

Top module: `lsp_top`

## Requirements
- R1: When the load sample is at or above the upper threshold, the period is `per_fast` clocks.
- R2: When the load sample is at or below the lower threshold, the period is `per_slow` clocks.
- R3: For a sample strictly between the thresholds, the period is `per_slow - floor((per_slow - per_fast) * (cur - thr_lo) / (thr_hi - thr_lo))`.
- R4: If `thr_hi` is not above `thr_lo`, the period is `per_fast` for every sample.
- R5: A change of the load sample or of the duty command takes effect only at the next cycle boundary. `per_now` shows the period in force and updates on the same clock edge that raises `smp_stb`.
- R6: `smp_stb` is high for exactly one clock at the start of every period, so consecutive strobes are exactly one period apart.
- R7: The on-time is `N = floor(duty * P / 4096)` clocks per period. `gate_main` is high for `N - dead` clocks of every period.
- R8: `gate_aux` is high for `P - N - dead` clocks of every period. The two gates are never high together, and with a nonzero dead time a gate rises only after the other gate has been low.
- R9: The on-time is limited to `P - dead`. A duty command that would exceed this limit yields `N = P - dead`.
- R10: After reset, `per_now` is 0 and both gates and the strobe are low. While `en` is low, both gates stay low and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable. When low, the gates are held off |
| load_cur | input | 12 | Unsigned load-current sample |
| duty_cmd | input | 12 | On-time as a fraction of the period, in units of 1/4096 |
| thr_hi | input | 12 | Upper current threshold (fast-period region) |
| thr_lo | input | 12 | Lower current threshold (slow-period region) |
| per_fast | input | 16 | Short period in clocks (high frequency) |
| per_slow | input | 16 | Long period in clocks (low frequency) |
| dead_time | input | 8 | Delay in clocks before each rising gate edge |
| gate_main | output | 1 | Main-switch gate |
| gate_aux | output | 1 | Auxiliary-switch gate |
| smp_stb | output | 1 | One-clock pulse at the start of each period |
| per_now | output | 16 | Period currently in force |

## Verification
The embedded properties check on every cycle that:
- the gates never overlap and a dead gap precedes each rising edge;
- the strobe lasts one clock;
- the period register changes only at a wrap, and the counter stays inside the period;
- a ramp-region period lies between the two limits;
- a disable forces both gates low.

Properties cannot state the arithmetic: the exact period in each load region, the interpolated value, the on-time and its saturation against the dead time. The directed scenarios show these by measuring strobe spacing and the number of high clocks on each gate over a full steady-state period. They also show that a mid-cycle change in the load sample waits for the next boundary.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int CUR_W   = 12;
    localparam int PER_W   = 16;
    localparam int DUTY_W  = 12;
    localparam int DT_W    = 8;
    localparam int MIN_PER = 4;

    typedef logic [PER_W-1:0] per_t;

    typedef enum logic [1:0] {
        REG_FAST   = 2'd0,
        REG_RAMP   = 2'd1,
        REG_SLOW   = 2'd2,
        REG_FORCED = 2'd3
    } region_e;

    typedef struct packed {
        per_t per;
        per_t on;
    } cyc_cfg_t;

    // on-time = floor(duty*per/2^DUTY_W), capped at per - dead
    function automatic per_t on_time(input logic [DUTY_W-1:0] duty,
                                     input per_t per,
                                     input logic [DT_W-1:0] dead);
        logic [PER_W+DUTY_W-1:0] prod;
        per_t raw;
        per_t cap;
        prod = (PER_W+DUTY_W)'(duty) * (PER_W+DUTY_W)'(per);
        raw  = prod[PER_W+DUTY_W-1:DUTY_W];
        cap  = (per > PER_W'(dead)) ? per - PER_W'(dead) : '0;
        return (raw > cap) ? cap : raw;
    endfunction

endpackage

// File: rtl/lsp_period_map.sv
module lsp_period_map
    import lsp_pkg::*;
#(
    parameter int CW = CUR_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] thr_hi,
    input  logic [CW-1:0] thr_lo,
    input  logic [PW-1:0] per_fast,
    input  logic [PW-1:0] per_slow,
    output logic [PW-1:0] per_next
);
    localparam int PROD_W = PW + CW;

    region_e          region;
    logic [PW-1:0]    span;
    logic [CW-1:0]    width;
    logic [CW-1:0]    delta;
    logic [CW-1:0]    divisor;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic [PW-1:0]    per_raw;

    always_comb begin
        span    = (per_slow > per_fast) ? per_slow - per_fast : '0;
        width   = thr_hi - thr_lo;
        delta   = cur - thr_lo;
        divisor = (width == '0) ? CW'(1) : width;
        prod    = PROD_W'(span) * PROD_W'(delta);
        quot    = prod / PROD_W'(divisor);

        if (thr_hi <= thr_lo) begin
            region  = REG_FORCED;
            per_raw = per_fast;
        end else if (cur >= thr_hi) begin
            region  = REG_FAST;
            per_raw = per_fast;
        end else if (cur <= thr_lo) begin
            region  = REG_SLOW;
            per_raw = per_slow;
        end else begin
            region  = REG_RAMP;
            per_raw = per_slow - quot[PW-1:0];
        end

        per_next = (per_raw < PW'(MIN_PER)) ? PW'(MIN_PER) : per_raw;
    end

    AST_RAMP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (region == REG_RAMP && per_slow >= per_fast && per_fast >= PW'(MIN_PER))
        |-> (per_next <= per_slow && per_next >= per_fast)); // R3

endmodule

// File: rtl/lsp_cycle_ctrl.sv
module lsp_cycle_ctrl
    import lsp_pkg::*;
#(
    parameter int PW = PER_W,
    parameter int DW = DUTY_W,
    parameter int TW = DT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] per_next,
    input  logic [DW-1:0] duty,
    input  logic [TW-1:0] dead,
    output logic          raw_main,
    output logic          raw_aux,
    output logic          stb,
    output logic [PW-1:0] per_cur
);
    logic          running;
    logic [PW-1:0] cnt;
    cyc_cfg_t      cfg;
    logic          wrap;

    assign wrap     = !running || (cnt == cfg.per - PW'(1));
    assign raw_main = running && (cnt < cfg.on);
    assign raw_aux  = running && !raw_main;
    assign per_cur  = cfg.per;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            cfg     <= '0;
            stb     <= 1'b0;
        end else if (!en) begin
            running <= 1'b0;
            cnt     <= '0;
            stb     <= 1'b0;
        end else if (wrap) begin
            running <= 1'b1;
            cnt     <= '0;
            cfg.per <= per_next;
            cfg.on  <= on_time(duty, per_next, dead);
            stb     <= 1'b1;
        end else begin
            cnt     <= cnt + PW'(1);
            stb     <= 1'b0;
        end
    end

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && running && !wrap) |=> $stable(cfg)); // R5

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb); // R6

    AST_CNT_INSIDE: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt < cfg.per)); // R6

endmodule

// File: rtl/lsp_dead_gate.sv
module lsp_dead_gate
    import lsp_pkg::*;
#(
    parameter int TW = DT_W,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [NCH-1:0] raw,
    input  logic [TW-1:0]  dead,
    output logic [NCH-1:0] gate
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [TW-1:0] hold;

        always_ff @(posedge clk) begin
            if (rst || !en) begin
                hold    <= '0;
                gate[g] <= 1'b0;
            end else begin
                if (raw[g]) hold <= (hold == '1) ? hold : hold + TW'(1);
                else        hold <= '0;
                gate[g] <= raw[g] && (hold >= dead);
            end
        end

        AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
            ($rose(gate[g]) && $past(dead) != '0) |-> !$past(gate[NCH-1-g])); // R8
    end

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gate[0] && gate[NCH-1])); // R8

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0)); // R10

endmodule

// File: rtl/lsp_top.sv
module lsp_top
    import lsp_pkg::*;
#(
    parameter int CW = CUR_W,
    parameter int PW = PER_W,
    parameter int DW = DUTY_W,
    parameter int TW = DT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] load_cur,
    input  logic [DW-1:0] duty_cmd,
    input  logic [CW-1:0] thr_hi,
    input  logic [CW-1:0] thr_lo,
    input  logic [PW-1:0] per_fast,
    input  logic [PW-1:0] per_slow,
    input  logic [TW-1:0] dead_time,
    output logic          gate_main,
    output logic          gate_aux,
    output logic          smp_stb,
    output logic [PW-1:0] per_now
);
    logic [PW-1:0] per_next;
    logic          raw_main;
    logic          raw_aux;
    logic [1:0]    gates;

    lsp_period_map #(.CW(CW), .PW(PW)) u_map (
        .clk      (clk),
        .rst      (rst),
        .cur      (load_cur),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .per_fast (per_fast),
        .per_slow (per_slow),
        .per_next (per_next)
    );

    lsp_cycle_ctrl #(.PW(PW), .DW(DW), .TW(TW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .per_next (per_next),
        .duty     (duty_cmd),
        .dead     (dead_time),
        .raw_main (raw_main),
        .raw_aux  (raw_aux),
        .stb      (smp_stb),
        .per_cur  (per_now)
    );

    lsp_dead_gate #(.TW(TW), .NCH(2)) u_gate (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .raw  ({raw_aux, raw_main}),
        .dead (dead_time),
        .gate (gates)
    );

    assign gate_main = gates[0];
    assign gate_aux  = gates[1];

endmodule

// File: tb/lsp_top_tb.sv
module lsp_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [11:0] load_cur  = '0;
    logic [11:0] duty_cmd  = '0;
    logic [11:0] thr_hi    = 12'd1638;
    logic [11:0] thr_lo    = 12'd901;
    logic [15:0] per_fast  = 16'd100;
    logic [15:0] per_slow  = 16'd467;
    logic [7:0]  dead_time = 8'd5;
    logic        gate_main, gate_aux, smp_stb;
    logic [15:0] per_now;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    lsp_top u_dut (
        .clk(clk), .rst(rst), .en(en), .load_cur(load_cur), .duty_cmd(duty_cmd),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .per_fast(per_fast), .per_slow(per_slow),
        .dead_time(dead_time), .gate_main(gate_main), .gate_aux(gate_aux),
        .smp_stb(smp_stb), .per_now(per_now)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wait_stb();
        do tick(); while (!smp_stb);
    endtask

    // one full period starting at a strobe: length, gate highs, strobe highs, overlap
    task automatic measure(output int p, output int hm, output int ha,
                           output int ns, output int ov);
        wait_stb();
        p = 0; hm = 0; ha = 0; ns = 0; ov = 0;
        do begin
            hm += int'(gate_main);
            ha += int'(gate_aux);
            ns += int'(smp_stb);
            ov += int'(gate_main && gate_aux);
            p++;
            tick();
        end while (!smp_stb);
    endtask

    function automatic int exp_per(int cur, int hi, int lo, int pf, int ps);
        int v;
        if (hi <= lo)       v = pf;
        else if (cur >= hi) v = pf;
        else if (cur <= lo) v = ps;
        else                v = ps - ((ps - pf) * (cur - lo)) / (hi - lo);
        return (v < 4) ? 4 : v;
    endfunction

    function automatic int exp_on(int duty, int p, int dt);
        int raw, cap;
        raw = (duty * p) / 4096;
        cap = (p > dt) ? p - dt : 0;
        return (raw > cap) ? cap : raw;
    endfunction

    task automatic run_case(input string req, input int cur, input int duty, input int dt);
        int p, hm, ha, ns, ov, ep, on;
        load_cur = 12'(cur); duty_cmd = 12'(duty); dead_time = 8'(dt);
        measure(p, hm, ha, ns, ov);
        measure(p, hm, ha, ns, ov);
        measure(p, hm, ha, ns, ov);
        ep = exp_per(cur, int'(thr_hi), int'(thr_lo), int'(per_fast), int'(per_slow));
        on = exp_on(duty, ep, dt);
        check({req, " period"}, p, ep);
        check({req, " per_now"}, int'(per_now), ep);
        check({req, " R7 main high"}, hm, (on > dt) ? on - dt : 0);
        check({req, " R8 aux high"}, ha, (ep - on > dt) ? ep - on - dt : 0);
        check({req, " R8 overlap"}, ov, 0);
        check({req, " R6 strobe count"}, ns, 1);
    endtask

    task automatic t_reset();
        check("R10 reset per_now", int'(per_now), 0);
        check("R10 reset gate_main", int'(gate_main), 0);
        check("R10 reset gate_aux", int'(gate_aux), 0);
        check("R10 reset strobe", int'(smp_stb), 0);
    endtask

    task automatic t_fast();  run_case("R1 fast", 2000, 2048, 5); endtask
    task automatic t_slow();  run_case("R2 slow", 500, 1024, 5);  endtask
    task automatic t_ramp();  run_case("R3 ramp", 1270, 2048, 5); endtask

    task automatic t_edges();
        run_case("R1 at upper threshold", 1638, 2048, 5);
        run_case("R2 at lower threshold", 901, 2048, 5);
        run_case("R3 ramp near lower", 902, 3000, 3);
    endtask

    task automatic t_forced();
        thr_hi = 12'd800; thr_lo = 12'd1000;
        run_case("R4 forced fast", 500, 2048, 5);
        thr_hi = 12'd1000; thr_lo = 12'd1000;
        run_case("R4 equal thresholds", 1000, 2048, 5);
        thr_hi = 12'd1638; thr_lo = 12'd901;
    endtask

    task automatic t_boundary();
        load_cur = 12'd2000; duty_cmd = 12'd2048; dead_time = 8'd5;
        wait_stb(); wait_stb();
        wait_stb();
        load_cur = 12'd500;
        repeat (3) tick();
        check("R5 per_now holds mid-cycle", int'(per_now), 100);
        wait_stb();
        check("R5 per_now at next boundary", int'(per_now), 467);
    endtask

    task automatic t_saturate();
        run_case("R9 saturated duty", 2000, 4095, 10);
    endtask

    task automatic t_zero_dead();
        run_case("R7 zero dead time", 2000, 2048, 0);
    endtask

    task automatic t_disable();
        int hi_cnt, stb_cnt;
        en = 1'b0;
        repeat (2) tick();
        hi_cnt = 0; stb_cnt = 0;
        for (int i = 0; i < 600; i++) begin
            hi_cnt  += int'(gate_main) + int'(gate_aux);
            stb_cnt += int'(smp_stb);
            tick();
        end
        check("R10 disabled gates low", hi_cnt, 0);
        check("R10 disabled no strobe", stb_cnt, 0);
        en = 1'b1;
        run_case("R10 restart", 2000, 2048, 5);
    endtask

    initial begin
        repeat (5) tick();
        rst = 1'b0;
        tick();
        t_reset();
        en = 1'b1;
        t_fast();
        t_slow();
        t_ramp();
        t_edges();
        t_forced();
        t_boundary();
        t_saturate();
        t_zero_dead();
        t_disable();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule